// File: doc/BRIEF.md
# Configurable External Interrupt Conditioner

This block accepts a bank of asynchronous interrupt pins from outside the chip and gives each one to an internal interrupt controller as a plain active-high level request. Each pin first passes through a two-flop synchronizer. Software then chooses, line by line, whether the pin is sensed as an edge or as a level, and which edge or which level counts as active.

An edge-sensed line records its event in a sticky latch, which software clears by writing ones to an acknowledge register. A level-sensed line follows the qualified pin directly and needs no acknowledge. A per-line mask gates every line onto the registered pending vector. The OR of that vector forms the group request.

Software reaches the block through a small word-addressed register port. Reads return data one cycle after the read strobe. Address map (3-bit word address):

| Address | Register | Behaviour |
|---|---|---|
| 0 | enable-set | writing 1 unmasks a line; reads back the mask |
| 1 | enable-clear | writing 1 masks a line; reads back the mask |
| 2 | acknowledge | writing 1 clears an edge latch; reads back the latches |
| 3 | mode | 1 = level, 0 = edge |
| 4 | edge direction | 1 = rising, 0 = falling |
| 5 | polarity | 1 = active high, 0 = active low |
| 6 | pending | read only; the pending vector |

Top module: `eic_top`

## Requirements
- R1: After reset the mask, the mode, edge-direction and polarity registers and all edge latches are zero, so every line is masked and set for falling edges; `pend_o` and `grp_req_o` are low.
- R2: Mode bit 1 (register address 3) makes a line level-sensed, and bit 0 makes it edge-sensed. In edge mode, a qualifying transition of the synchronized pin sets a sticky latch that stays set after the pin returns. Transitions while in level mode set no latch.
- R3: In edge mode, edge-direction bit 1 (address 4) selects rising transitions and bit 0 selects falling ones. The opposite transition sets nothing.
- R4: In level mode, polarity bit 1 (address 5) makes a high pin active and bit 0 makes a low pin active. The line's request follows the pin, with no acknowledge needed.
- R5: Writing 1s to address 0 unmasks those lines, and writing 1s to address 1 masks them. Zero bits in either write leave the mask unchanged. Both addresses read back the mask.
- R6: Writing 1s to address 2 clears those edge latches; zero bits leave a latch unchanged. An acknowledge has no effect on a level-sensed line's request. Address 2 reads back the latches.
- R7: Configuration registers store bits only for the NUM_LINES implemented lines and read back the stored value. Bits above NUM_LINES read as 0, so writing all ones and reading back gives the line count.
- R8: `pend_o` equals (edge latch in edge mode, or qualified level in level mode) AND mask, registered one cycle. `grp_req_o` is the OR of those bits. Address 6 reads the pending vector.
- R9: Masking a line hides it from `pend_o` but does not clear its edge latch. Unmasking it later shows the held event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| pend_o | output | NUM_LINES | Per-line pending requests, active high |
| grp_req_o | output | 1 | OR of all pending lines |

## Verification
On every cycle, the embedded assertions check the following:
- set and clear writes affect exactly the ones-bits of the mask;
- configuration writes are stored;
- an acknowledge clears a latch unless a new edge arrives in the same cycle;
- a latch never drops without an acknowledge, and never sets in level mode;
- a masked line never shows as pending.

Only the bench scenarios can show the following:
- the selected edge versus the opposite edge;
- the line count found by writing all ones;
- level-line behaviour under acknowledge;
- the return of a held event after it is unmasked.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN_SET = 3'd0,
    REG_EN_CLR = 3'd1,
    REG_ACK    = 3'd2,
    REG_MODE   = 3'd3,
    REG_EDGE   = 3'd4,
    REG_POL    = 3'd5,
    REG_PEND   = 3'd6
  } eic_reg_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int NUM_LINES = 8,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] sync_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
      end
      assign sync_o[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/eic_detect.sv
module eic_detect #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] sync_i,
  input  logic [NUM_LINES-1:0] mode_i,
  input  logic [NUM_LINES-1:0] edge_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] latch_o,
  output logic [NUM_LINES-1:0] raw_o
);
  logic [NUM_LINES-1:0] prev_q, latch_q, hit, lvl;

  // rising where direction=1, falling where direction=0
  assign hit = (edge_i & sync_i & ~prev_q) | (~edge_i & ~sync_i & prev_q);
  assign lvl = ~(sync_i ^ pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_i;
      // a new edge in the same cycle as an acknowledge wins
      latch_q <= (latch_q & ~ack_i) | (hit & ~mode_i);
    end
  end

  assign latch_o = latch_q;
  assign raw_o   = (mode_i & lvl) | (~mode_i & latch_q);

  // R6: acknowledged latch clears unless a fresh edge arrived
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ack_i) & ~($past(hit) & ~$past(mode_i))) & latch_q) == '0);
  // R9: a latch only falls through an acknowledge
  p_latch_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(latch_q) & ~$past(ack_i) & ~latch_q) == '0);
  // R2: level-mode lines never set a latch
  p_level_no_set_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(mode_i) & ~$past(latch_q) & latch_q) == '0);
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] latch_i,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] edge_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] ack_o,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [NUM_LINES-1:0] mask_q, mode_q, edge_q, pol_q, rd_val;
  logic [DATA_W-1:0]    rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      mode_q <= '0;
      edge_q <= '0;
      pol_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_EN_SET: mask_q <= mask_q | wdata_i;
        REG_EN_CLR: mask_q <= mask_q & ~wdata_i;
        REG_MODE:   mode_q <= wdata_i;
        REG_EDGE:   edge_q <= wdata_i;
        REG_POL:    pol_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ack_o = (wr_i && addr_i == REG_ACK) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_EN_SET, REG_EN_CLR: rd_val = mask_q;
      REG_ACK:  rd_val = latch_i;
      REG_MODE: rd_val = mode_q;
      REG_EDGE: rd_val = edge_q;
      REG_POL:  rd_val = pol_q;
      REG_PEND: rd_val = pend_i;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= DATA_W'(rd_val);
  end

  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign edge_o  = edge_q;
  assign pol_o   = pol_q;
  assign rdata_o = rdata_q;

  // R5: set write turns on exactly its ones-bits
  p_set_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == REG_EN_SET) |=>
      mask_q == ($past(mask_q) | $past(wdata_i)));
  // R5: clear write turns off exactly its ones-bits
  p_clr_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == REG_EN_CLR) |=>
      mask_q == ($past(mask_q) & ~$past(wdata_i)));
  // R7: mode write is stored for the implemented lines
  p_mode_store_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == REG_MODE) |=> mode_q == $past(wdata_i));
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] ext_pin_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 grp_req_o
);
  logic [NUM_LINES-1:0] sync_w, mask_w, mode_w, edge_w, pol_w, ack_w;
  logic [NUM_LINES-1:0] latch_w, raw_w, pend_q, pend_n;
  logic                 grp_q;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  eic_sync #(.NUM_LINES(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i), .sync_o(sync_w));

  eic_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk(clk), .rst(rst), .sync_i(sync_w), .mode_i(mode_w),
    .edge_i(edge_w), .pol_i(pol_w), .ack_i(ack_w),
    .latch_o(latch_w), .raw_o(raw_w));

  eic_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i[NUM_LINES-1:0]),
    .latch_i(latch_w), .pend_i(pend_q), .mask_o(mask_w),
    .mode_o(mode_w), .edge_o(edge_w), .pol_o(pol_w),
    .ack_o(ack_w), .rdata_o(reg_rdata_o));

  assign pend_n = raw_w & mask_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      grp_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      grp_q  <= |pend_n;
    end
  end

  assign pend_o    = pend_q;
  assign grp_req_o = grp_q;

  // R8: a masked line never reaches the pending output
  p_pend_masked_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend_o & ~$past(mask_w)) == '0);
  // R8: group request agrees with the pending vector
  p_grp_consistent_r8: assert property (@(posedge clk) disable iff (rst)
    grp_req_o == (pend_o != '0));
  // R1: outputs quiet in the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $fell(rst) |-> (pend_o == '0 && !grp_req_o));
endmodule

// File: tb/tb_eic_top.sv
module tb_eic_top;
  localparam int N  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins = '1;
  logic          wr = 1'b0, rd = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  pend;
  logic          grp;

  always #2.5 clk = ~clk;

  eic_top #(.NUM_LINES(N), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .ext_pin_i(pins), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pend_o(pend), .grp_req_o(grp));

  typedef struct {
    int          kind;   // 0 pending vector, 1 group request, 2 read data
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;

  // monitor: pops expected items and compares with live outputs
  initial begin
    forever begin
      wait (q.size() != 0);
      begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = 32'(pend);
          1:       act = 32'(grp);
          default: act = rdata;
        endcase
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    push(2, exp, tag);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_out(logic [N-1:0] p, string tag);
    push(0, 32'(p), tag);
    push(1, 32'(p != '0), tag);
  endtask

  task automatic set_pin(int i, logic v);
    @(negedge clk); pins[i] = v;
    settle();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_out('0, "R1 outputs after reset");
    reg_read(3'd3, 0, "R1 mode reset");
    reg_read(3'd0, 0, "R1 mask reset");
    reg_read(3'd2, 0, "R1 latch reset");
    settle();
    expect_out('0, "R1 idle pins no request");

    // R7 line count discovery
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_read(3'd3, 32'h0000_00FF, "R7 mode all ones readback");
    reg_write(3'd3, 0);
    reg_read(3'd3, 0, "R7 mode cleared");

    // R5 mask set/clear with zero bits
    reg_write(3'd0, 32'h0F);
    reg_read(3'd0, 32'h0F, "R5 set mask");
    reg_write(3'd0, 0);
    reg_write(3'd1, 0);
    reg_read(3'd1, 32'h0F, "R5 zero writes no effect");
    reg_write(3'd1, 32'h08);
    reg_read(3'd0, 32'h07, "R5 clear one bit");

    // R2 falling edge latch (default direction)
    set_pin(0, 1'b0);
    expect_out(8'h01, "R2 falling edge latched");
    set_pin(0, 1'b1);
    expect_out(8'h01, "R2 latch sticky after pin returns");
    reg_write(3'd2, 32'h02);
    settle();
    expect_out(8'h01, "R6 ack zero bit leaves latch");
    reg_write(3'd2, 32'h01);
    settle();
    expect_out(8'h00, "R6 ack clears latch");

    // R3 rising edge
    reg_write(3'd4, 32'h02);
    reg_read(3'd4, 32'h02, "R7 edge readback");
    set_pin(1, 1'b0);
    expect_out(8'h00, "R3 falling ignored in rising mode");
    set_pin(1, 1'b1);
    expect_out(8'h02, "R3 rising edge latched");
    reg_write(3'd2, 32'h02);
    settle();
    expect_out(8'h00, "R3 cleared");

    // R4 level mode, active low then active high
    reg_write(3'd3, 32'h04);
    settle();
    expect_out(8'h00, "R4 active low, pin high");
    set_pin(2, 1'b0);
    expect_out(8'h04, "R4 active low, pin low");
    reg_write(3'd2, 32'h04);
    settle();
    expect_out(8'h04, "R6 ack no effect on level line");
    reg_read(3'd2, 0, "R2 level transitions set no latch");
    set_pin(2, 1'b1);
    expect_out(8'h00, "R4 follows pin without ack");
    reg_write(3'd5, 32'h04);
    settle();
    expect_out(8'h04, "R4 active high, pin high");
    reg_read(3'd5, 32'h04, "R7 polarity readback");
    set_pin(2, 1'b0);
    expect_out(8'h00, "R4 active high, pin low");

    // R9 masking keeps latch
    reg_write(3'd1, 32'h01);
    set_pin(0, 1'b0);
    expect_out(8'h00, "R8 masked line hidden");
    reg_read(3'd2, 32'h01, "R9 latch kept while masked");
    reg_write(3'd0, 32'h01);
    settle();
    expect_out(8'h01, "R9 event shown after unmask");
    reg_write(3'd2, 32'h01);
    settle();
    expect_out(8'h00, "R6 cleared after unmask");

    // R8 several lines together
    reg_write(3'd0, 32'hF0);
    @(negedge clk); pins[4] = 1'b0; pins[5] = 1'b0;
    settle();
    expect_out(8'h30, "R8 two lines pending");
    reg_read(3'd6, 32'h30, "R8 pending register view");
    reg_write(3'd2, 32'h30);
    settle();
    expect_out(8'h00, "R8 group request drops");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule